// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the device-side end of a four-wire serial configuration port. An external host drives a serial clock, a data line and an active-low select. It uses them to write and read a bank of 8-bit configuration registers. Every register is also presented in parallel to the internal logic that the registers control. The slave runs on a faster system clock and oversamples the serial clock. Two-stage synchronizers on the serial clock, the select and the data input feed edge detectors, which produce the strobes for sampling and shifting.

A transaction is one 16-bit frame, sent while select is held low. Seven address bits come first, most significant first. A direction flag follows: 1 requests a write and 0 requests a read. Eight data bits close the frame, D7 first. The host changes the data line on falling serial-clock edges and the slave samples it on rising edges. A write commits the assembled byte only once the final data bit has been sampled. On a read, the slave shifts the addressed byte out on its data-out line and changes it on falling edges, so the host can sample it on rising edges within the same frame. Select must go high between frames. A rising select abandons any partly sent frame.

Top module: `serial_cfg_slave`

## Requirements
- R1: After asynchronous reset every register holds RESET_VAL (default 0xA5), and both serDout and serDoutEn are low.
- R2: A frame is bit 0..6 = address A6..A0, bit 7 = direction (1 write, 0 read), bits 8..15 = data D7..D0, each sampled on a rising serClk edge while serSelN is low. A write frame to an address below NUM_REGS (default 33) stores the data byte in that register.
- R3: A write changes a register only after the sixteenth bit (D0) has been sampled. If select rises after 15 or fewer bits, no register changes.
- R4: In a read frame, serDout presents D7..D0 of the addressed register during bits 8..15, each bit set up after a falling serClk edge and held while serClk is high.
- R5: serDoutEn is high only during the data bits of a read frame. serDout is low whenever serDoutEn is low, including the address and direction bits and while select is high.
- R6: A write to an address at or above NUM_REGS leaves every register unchanged, and a read of such an address returns 0x00.
- R7: A rising select ends the frame. The next frame starts again from address bit A6, and no register changes while select is high.
- R8: A read frame leaves the register contents unchanged.
- R9: Bits clocked after the sixteenth bit of a frame are ignored until select rises.
- R10: Output regBank bits [8*i+7:8*i] always show register i, and registers may be written in any order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial interface |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock from the host |
| serSelN | input | 1 | Active-low frame select from the host |
| serDin | input | 1 | Serial data from the host |
| serDout | output | 1 | Serial read data to the host |
| serDoutEn | output | 1 | High while serDout carries read data (output driver enable) |
| regBank | output | NUM_REGS*DATA_W | All registers in parallel, register i at bits [8*i+7:8*i] |

## Verification
If the bit counter goes wrong, the fault shows within the same frame. Either the wrong register changes on regBank a few system cycles after the sixteenth rising edge, or the enable window on serDoutEn opens one bit early or late. If the read shadow or the address latch goes wrong, the host samples a wrong bit on serDout at the very next rising edge. A missing abort shows only on the following frame: the next byte lands at a shifted address or is never committed.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  // One-cycle strobes issued by the control unit to the datapath.
  typedef struct packed {
    logic sampleBit;   // shift the synchronized input bit in
    logic latchAddr;   // address bits complete, capture them
    logic loadRead;    // read frame: copy addressed register to shadow
    logic driveBit;    // falling edge in read phase: present next bit
    logic finishRead;  // last read bit consumed by host
    logic commit;      // write frame: store assembled byte
    logic abort;       // select went high: drop the frame
  } ctrlStrobes_t;

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serSelN,
  input  logic serDin,
  output logic sclkLvl,
  output logic sclkRise,
  output logic sclkFall,
  output logic selHigh,
  output logic selRise,
  output logic dinSync
);

  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_LVL = 3'b010; // {din, sel, sclk}

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] syncOut;
  logic [NSIG-1:0] delayed;

  assign rawIn = {serDin, serSelN, serClk};

  for (genvar s = 0; s < NSIG; s++) begin : gSig
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{IDLE_LVL[s]}};
      else       chain <= {chain[STAGES-2:0], rawIn[s]};
    end
    assign syncOut[s] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) delayed <= IDLE_LVL;
    else       delayed <= syncOut;
  end

  assign sclkLvl  = syncOut[0];
  assign sclkRise = syncOut[0] & ~delayed[0];
  assign sclkFall = ~syncOut[0] & delayed[0];
  assign selHigh  = syncOut[1];
  assign selRise  = syncOut[1] & ~delayed[1];
  assign dinSync  = syncOut[2];

endmodule

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
  import scfg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkRise,
  input  logic         sclkFall,
  input  logic         selHigh,
  input  logic         selRise,
  input  logic         dinSync,
  output ctrlStrobes_t strobes,
  output logic         readActive
);

  localparam int FRAME_BITS = ADDR_W + 1 + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] RW_POS   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] bitCnt;
  logic             isWrite;
  logic             inFrame;

  assign inFrame = ~selHigh & (bitCnt != FULL_CNT);

  always_comb begin
    strobes = '0;
    if (selRise) begin
      strobes.abort = 1'b1;
    end else begin
      if (inFrame && sclkRise) begin
        strobes.sampleBit = 1'b1;
        if (bitCnt == RW_POS) begin
          strobes.latchAddr = 1'b1;
          strobes.loadRead  = ~dinSync;
        end
        if (bitCnt == LAST_POS) begin
          strobes.commit     = isWrite;
          strobes.finishRead = readActive;
        end
      end
      if (!selHigh && sclkFall && readActive) strobes.driveBit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      isWrite    <= 1'b0;
      readActive <= 1'b0;
    end else if (strobes.abort) begin
      bitCnt     <= '0;
      isWrite    <= 1'b0;
      readActive <= 1'b0;
    end else if (strobes.sampleBit) begin
      bitCnt <= bitCnt + 1'b1;
      if (strobes.latchAddr) begin
        isWrite    <= dinSync;
        readActive <= ~dinSync;
      end
      if (strobes.finishRead) readActive <= 1'b0;
      if (bitCnt == LAST_POS) isWrite <= 1'b0;
    end
  end

endmodule

// File: rtl/scfg_dpath.sv
module scfg_dpath
  import scfg_pkg::*;
#(
  parameter int          ADDR_W    = 7,
  parameter int          DATA_W    = 8,
  parameter int          NUM_REGS  = 33,
  parameter logic [7:0]  RESET_VAL = 8'hA5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strobes,
  input  logic                         dinSync,
  output logic                         doutBit,
  output logic [NUM_REGS*DATA_W-1:0]   bankFlat
);

  logic [DATA_W-1:0] shiftReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] readShadow;
  logic [DATA_W-1:0] readVal;
  logic [DATA_W-1:0] newByte;
  logic [DATA_W-1:0] bank [NUM_REGS];

  assign newByte = {shiftReg[DATA_W-2:0], dinSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
    end else begin
      if (strobes.sampleBit) shiftReg <= newByte;
      if (strobes.latchAddr) addrReg  <= shiftReg[ADDR_W-1:0];
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(r);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   bank[r] <= DATA_W'(RESET_VAL);
      else if (strobes.commit && addrReg == MY_ADDR) bank[r] <= newByte;
    end
    assign bankFlat[r*DATA_W +: DATA_W] = bank[r];
  end

  // Address in the shift register at the moment the direction bit arrives.
  always_comb begin
    readVal = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (shiftReg[ADDR_W-1:0] == ADDR_W'(r)) readVal = bank[r];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readShadow <= '0;
      doutBit    <= 1'b0;
    end else if (strobes.abort || strobes.finishRead) begin
      readShadow <= '0;
      doutBit    <= 1'b0;
    end else if (strobes.loadRead) begin
      readShadow <= readVal;
      doutBit    <= 1'b0;
    end else if (strobes.driveBit) begin
      doutBit    <= readShadow[DATA_W-1];
      readShadow <= {readShadow[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/serial_cfg_slave.sv
module serial_cfg_slave
  import scfg_pkg::*;
#(
  parameter int         ADDR_W    = 7,
  parameter int         DATA_W    = 8,
  parameter int         NUM_REGS  = 33,
  parameter int         SYNC_LEN  = 2,
  parameter logic [7:0] RESET_VAL = 8'hA5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serClk,
  input  logic                       serSelN,
  input  logic                       serDin,
  output logic                       serDout,
  output logic                       serDoutEn,
  output logic [NUM_REGS*DATA_W-1:0] regBank
);

  logic         sclkLvl;
  logic         sclkRise;
  logic         sclkFall;
  logic         selHigh;
  logic         selRise;
  logic         dinSync;
  logic         readActive;
  ctrlStrobes_t strobes;

  scfg_sync #(.STAGES(SYNC_LEN)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .serClk   (serClk),
    .serSelN  (serSelN),
    .serDin   (serDin),
    .sclkLvl  (sclkLvl),
    .sclkRise (sclkRise),
    .sclkFall (sclkFall),
    .selHigh  (selHigh),
    .selRise  (selRise),
    .dinSync  (dinSync)
  );

  scfg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclkRise   (sclkRise),
    .sclkFall   (sclkFall),
    .selHigh    (selHigh),
    .selRise    (selRise),
    .dinSync    (dinSync),
    .strobes    (strobes),
    .readActive (readActive)
  );

  scfg_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dinSync  (dinSync),
    .doutBit  (serDout),
    .bankFlat (regBank)
  );

  assign serDoutEn = readActive;

endmodule

// File: rtl/scfg_checker.sv
module scfg_checker #(
  parameter int BANK_W = 264
) (
  input logic              clk,
  input logic              rstN,
  input logic              serDout,
  input logic              serDoutEn,
  input logic [BANK_W-1:0] regBank,
  input logic              selHigh,
  input logic              sclkLvl,
  input logic              sclkRise
);

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !serDoutEn |-> !serDout); // R5

  AST_EN_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    selHigh && $past(selHigh) |-> !serDoutEn); // R5

  AST_DOUT_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    serDoutEn && $past(serDoutEn) && sclkLvl && $past(sclkLvl) |-> $stable(serDout)); // R4

  AST_BANK_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regBank) |-> $past(sclkRise)); // R3

  AST_BANK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    selHigh && $past(selHigh) |-> $stable(regBank)); // R7

endmodule

bind serial_cfg_slave scfg_checker #(.BANK_W(NUM_REGS*DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .serDout   (serDout),
  .serDoutEn (serDoutEn),
  .regBank   (regBank),
  .selHigh   (selHigh),
  .sclkLvl   (sclkLvl),
  .sclkRise  (sclkRise)
);

// File: tb/serial_cfg_slave_test.sv
`timescale 1ns/1ps
module serial_cfg_slave_test;

  localparam int NREG = 33;
  localparam logic [7:0] RST_VAL = 8'hA5;
  localparam time HALF = 40ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serSelN = 1'b1;
  logic serDin = 1'b0;
  logic serDout;
  logic serDoutEn;
  logic [NREG*8-1:0] regBank;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NREG];

  always #2.5ns clk = ~clk;

  serial_cfg_slave uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serSelN(serSelN),
    .serDin(serDin), .serDout(serDout), .serDoutEn(serDoutEn), .regBank(regBank)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends nBits of {addr, rw, data} (extra bits are 1s); returns sampled read byte
  // and the count of bits where serDoutEn differed from the expected window.
  task automatic xfer(input logic [6:0] a, input logic rw, input logic [7:0] d,
                      input int nBits, output logic [7:0] rd, output int enBad);
    logic [15:0] frame;
    frame = {a, rw, d};
    rd = '0;
    enBad = 0;
    serSelN = 1'b0;
    #HALF;
    for (int i = 0; i < nBits; i++) begin
      serDin = (i < 16) ? frame[15-i] : 1'b1;
      #HALF;
      if (i >= 8 && i < 16) rd[15-i] = serDout;
      if (serDoutEn != (!rw && i >= 8 && i < 16)) enBad++;
      serClk = 1'b1;
      #HALF;
      serClk = 1'b0;
    end
    #HALF;
    serSelN = 1'b1;
    #(4*HALF);
  endtask

  task automatic writeReg(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rd;
    int bad;
    xfer(a, 1'b1, d, 16, rd, bad);
    if (a < NREG) model[a] = d;
  endtask

  task automatic checkBank(input string req);
    int bad = 0;
    for (int r = 0; r < NREG; r++) if (regBank[r*8 +: 8] != model[r]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic testReset;
    for (int r = 0; r < NREG; r++) model[r] = RST_VAL;
    checkBank("R1 bank reset");
    check(serDout == 1'b0 && serDoutEn == 1'b0, "R1 outputs reset", {serDout, serDoutEn}, 0);
  endtask

  task automatic testWriteRead;
    logic [7:0] rd;
    int bad;
    // R10: out-of-order addresses; R2: frame format
    writeReg(7'd32, 8'h81);
    writeReg(7'd0,  8'h5A);
    writeReg(7'd17, 8'hC3);
    writeReg(7'd1,  8'hFF);
    writeReg(7'd2,  8'h00);
    checkBank("R2 R10 parallel bank after writes");
    check(regBank[32*8 +: 8] == 8'h81, "R10 top register", regBank[32*8 +: 8], 8'h81);
    foreach (model[r]) begin
      if (r == 0 || r == 1 || r == 17 || r == 32 || r == 5) begin
        xfer(7'(r), 1'b0, 8'h00, 16, rd, bad);
        check(rd == model[r], "R4 serial read data", rd, model[r]);
        check(bad == 0, "R5 enable window", bad, 0);
      end
    end
    checkBank("R8 bank after reads");
    check(serDout == 1'b0 && serDoutEn == 1'b0, "R5 idle outputs", {serDout, serDoutEn}, 0);
  endtask

  task automatic testAbort;
    logic [7:0] rd;
    int bad;
    writeReg(7'd3, 8'h11);
    xfer(7'd3, 1'b1, 8'hEE, 15, rd, bad);
    check(regBank[3*8 +: 8] == 8'h11, "R3 no commit before D0", regBank[3*8 +: 8], 8'h11);
    xfer(7'd3, 1'b1, 8'h66, 10, rd, bad);
    check(regBank[3*8 +: 8] == 8'h11, "R7 aborted frame", regBank[3*8 +: 8], 8'h11);
    writeReg(7'd3, 8'hEE);
    check(regBank[3*8 +: 8] == 8'hEE, "R7 next frame restarts", regBank[3*8 +: 8], 8'hEE);
    xfer(7'd17, 1'b0, 8'h00, 12, rd, bad);
    xfer(7'd17, 1'b0, 8'h00, 16, rd, bad);
    check(rd == 8'hC3, "R7 read after aborted read", rd, 8'hC3);
    checkBank("R3 bank after aborts");
  endtask

  task automatic testOutOfRange;
    logic [7:0] rd;
    int bad;
    writeReg(7'd33, 8'h77);
    writeReg(7'd127, 8'h3E);
    checkBank("R6 write beyond bank ignored");
    xfer(7'd33, 1'b0, 8'h00, 16, rd, bad);
    check(rd == 8'h00, "R6 read at 33", rd, 0);
    xfer(7'd100, 1'b0, 8'h00, 16, rd, bad);
    check(rd == 8'h00, "R6 read at 100", rd, 0);
    check(bad == 0, "R5 enable window out of range", bad, 0);
  endtask

  task automatic testExtraBits;
    logic [7:0] rd;
    int bad;
    xfer(7'd5, 1'b1, 8'h3C, 21, rd, bad);
    model[5] = 8'h3C;
    check(regBank[5*8 +: 8] == 8'h3C, "R9 extra bits ignored", regBank[5*8 +: 8], 8'h3C);
    xfer(7'd5, 1'b0, 8'h00, 20, rd, bad);
    check(rd == 8'h3C && bad == 0, "R9 read with extra clocks", {rd, 8'(bad)}, {8'h3C, 8'h0});
    checkBank("R9 bank after long frames");
  endtask

  initial begin : watchdog
    #(150000 * 5ns);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #31ns;
    testReset();
    rstN = 1'b1;
    #(4*HALF + 1ns);
    testReset();
    testWriteRead();
    testAbort();
    testOutOfRange();
    testExtraBits();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule